// File: doc/BRIEF.md
# Timer Output-Compare Match Unit

This block sits next to a free-running timer counter and watches it. Software loads a compare value through a write port. Once the counter reaches that value, the block raises a compare flag one timer-clock cycle later. It also drives an interrupt request while the flag is set, provided the local and global interrupt enables allow it. The flag clears when the processor takes the interrupt vector, signalled by an acknowledge pulse, or when software writes a one to the flag bit.

Every match also updates a waveform output bit through a programmable two-bit action. A force strobe applies the same action at once, with no match needed. A forced compare never touches the flag. The block does not contain the counter, the prescaler or any PWM mode. The timer-clock enable marks the system-clock cycles on which the counter is valid.

Top module: `ocmp_unit`

## Requirements
- R1: When the counter equals the compare value on a cycle with `tick` high, `cmp_flag` goes to 1 at the clock edge of the next `tick`-high cycle, and not earlier.
- R2: A `force_cmp` strobe never sets `cmp_flag`.
- R3: A `vec_ack` pulse clears `cmp_flag` at the next clock edge.
- R4: A write with `flag_wr` high and `flag_wdata` equal to 1 clears `cmp_flag`. A write with `flag_wdata` equal to 0 leaves the flag unchanged.
- R5: `irq` is 1 exactly when `cmp_flag`, `irq_en` and `gie` are all 1. It is combinational from these inputs and the flag.
- R6: On a match, or when `force_cmp` is high, `wave_out` is updated at the clock edge according to `wave_act`: 2'b00 holds, 2'b01 toggles, 2'b10 drives 0, 2'b11 drives 1. A match and a force in the same cycle apply the action once. With neither present, `wave_out` holds.
- R7: After a compare-value write, the next `tick`-high cycle cannot produce a match, even if the count equals the new value.
- R8: Matches are evaluated only on `tick`-high cycles. The pending match waits through `tick`-low cycles and sets the flag on the next `tick`-high cycle.
- R9: If a hardware flag set coincides with `vec_ack` or a clear-by-one write, the flag ends up set.
- R10: Synchronous active-high `rst` clears the flag, the pending match, the compare value and `wave_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer-clock enable; the count is valid in this cycle |
| count | input | CNT_W | Current counter value |
| cmp_wr | input | 1 | Compare-value write strobe |
| cmp_wdata | input | CNT_W | New compare value |
| irq_en | input | 1 | Compare interrupt enable |
| gie | input | 1 | Global interrupt enable |
| wave_act | input | 2 | Waveform action code (see R6) |
| force_cmp | input | 1 | Forced compare strobe |
| flag_wr | input | 1 | Flag-register write strobe |
| flag_wdata | input | 1 | Bit written to the flag position; 1 clears |
| vec_ack | input | 1 | Interrupt vector taken |
| cmp_flag | output | 1 | Output-compare flag |
| irq | output | 1 | Interrupt request |
| wave_out | output | 1 | Waveform output bit |

## Verification
The hardest situation to reach is a pending match that has been captured but has not yet reached the flag. Reaching it takes a match on a `tick`-high cycle followed by several `tick`-low cycles. The bench drives that exact pattern and checks that the flag stays low until the next `tick` arrives. It also lands a vector acknowledge on the very cycle the pending match sets the flag, to show that the set wins. The write-block window is reached by writing a compare value one above the current count and presenting that count on the next cycle.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    typedef enum logic [1:0] {
        WAVE_HOLD   = 2'b00,
        WAVE_TOGGLE = 2'b01,
        WAVE_LOW    = 2'b10,
        WAVE_HIGH   = 2'b11
    } wave_act_e;

    typedef struct packed {
        logic matched;
        logic forced;
    } cmp_evt_t;

    function automatic logic wave_next(wave_act_e act, logic cur);
        case (act)
            WAVE_TOGGLE: wave_next = ~cur;
            WAVE_LOW:    wave_next = 1'b0;
            WAVE_HIGH:   wave_next = 1'b1;
            default:     wave_next = cur;
        endcase
    endfunction

    function automatic logic flag_next(logic cur, logic set_req, logic clr_req);
        if (set_req)
            flag_next = 1'b1;
        else if (clr_req)
            flag_next = 1'b0;
        else
            flag_next = cur;
    endfunction

endpackage

// File: rtl/ocmp_match.sv
module ocmp_match #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic             hit
);
    logic [CNT_W-1:0] cmp_val;
    logic             wr_block;

    // a write arms a one-shot block for the next tick-high cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_val  <= '0;
            wr_block <= 1'b0;
        end else begin
            if (cmp_wr) begin
                cmp_val  <= cmp_wdata;
                wr_block <= 1'b1;
            end else if (tick) begin
                wr_block <= 1'b0;
            end
        end
    end

    assign hit = tick && !wr_block && (count == cmp_val);
endmodule

// File: rtl/ocmp_flag.sv
module ocmp_flag (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hit,
    input  logic flag_wr,
    input  logic flag_wdata,
    input  logic vec_ack,
    output logic flag
);
    import ocmp_pkg::*;

    logic hit_pend;
    logic set_req;
    logic clr_req;

    assign set_req = tick && hit_pend;
    assign clr_req = vec_ack || (flag_wr && flag_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_pend <= 1'b0;
            flag     <= 1'b0;
        end else begin
            if (tick)
                hit_pend <= hit;
            flag <= flag_next(flag, set_req, clr_req);
        end
    end
endmodule

// File: rtl/ocmp_wave.sv
module ocmp_wave (
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    input  logic       force_cmp,
    input  logic [1:0] wave_act,
    output logic       wave_out
);
    import ocmp_pkg::*;

    cmp_evt_t  evt;
    wave_act_e act;

    assign evt.matched = hit;
    assign evt.forced  = force_cmp;
    assign act         = wave_act_e'(wave_act);

    always_ff @(posedge clk) begin
        if (rst)
            wave_out <= 1'b0;
        else if (evt.matched || evt.forced)
            wave_out <= wave_next(act, wave_out);
    end
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             irq_en,
    input  logic             gie,
    input  logic [1:0]       wave_act,
    input  logic             force_cmp,
    input  logic             flag_wr,
    input  logic             flag_wdata,
    input  logic             vec_ack,
    output logic             cmp_flag,
    output logic             irq,
    output logic             wave_out
);
    logic hit;

    ocmp_match #(.CNT_W(CNT_W)) u_match (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .count     (count),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .hit       (hit)
    );

    ocmp_flag u_flag (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .hit        (hit),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .vec_ack    (vec_ack),
        .flag       (cmp_flag)
    );

    ocmp_wave u_wave (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .force_cmp (force_cmp),
        .wave_act  (wave_act),
        .wave_out  (wave_out)
    );

    assign irq = cmp_flag && irq_en && gie;
endmodule

// File: rtl/ocmp_checker.sv
module ocmp_checker (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic cmp_wr,
    input logic hit,
    input logic force_cmp,
    input logic flag_wr,
    input logic flag_wdata,
    input logic vec_ack,
    input logic irq_en,
    input logic gie,
    input logic cmp_flag,
    input logic irq,
    input logic wave_out
);
    AST_FLAG_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(cmp_flag) |-> $past(tick)); // R1

    AST_FLAG_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(cmp_flag) |-> $past(vec_ack || (flag_wr && flag_wdata))); // R3

    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (cmp_flag && !vec_ack && !(flag_wr && flag_wdata)) |=> cmp_flag); // R4

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cmp_flag && irq_en && gie)); // R5

    AST_WAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(hit || force_cmp) |=> $stable(wave_out)); // R6

    AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        cmp_wr |=> !(tick && hit)); // R7

    AST_HIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        hit |-> tick); // R8
endmodule

bind ocmp_unit ocmp_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .cmp_wr     (cmp_wr),
    .hit        (hit),
    .force_cmp  (force_cmp),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .vec_ack    (vec_ack),
    .irq_en     (irq_en),
    .gie        (gie),
    .cmp_flag   (cmp_flag),
    .irq        (irq),
    .wave_out   (wave_out)
);

// File: tb/tb_ocmp_unit.sv
module tb_ocmp_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] count = '0;
    logic       cmp_wr = 1'b0;
    logic [7:0] cmp_wdata = '0;
    logic       irq_en = 1'b1;
    logic       gie = 1'b1;
    logic [1:0] wave_act = 2'b01;
    logic       force_cmp = 1'b0;
    logic       flag_wr = 1'b0;
    logic       flag_wdata = 1'b0;
    logic       vec_ack = 1'b0;
    logic       cmp_flag, irq, wave_out;

    always #4 clk = ~clk;

    ocmp_unit #(.CNT_W(8)) dut (
        .clk(clk), .rst(rst), .tick(tick), .count(count),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .irq_en(irq_en), .gie(gie),
        .wave_act(wave_act), .force_cmp(force_cmp), .flag_wr(flag_wr),
        .flag_wdata(flag_wdata), .vec_ack(vec_ack),
        .cmp_flag(cmp_flag), .irq(irq), .wave_out(wave_out)
    );

    typedef struct {
        string req;
        bit    flag;
        bit    irq;
        bit    wave;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;

    // reference state, kept from the requirement text
    bit [7:0] m_cmp = '0;
    bit       m_blk = 1'b0;
    bit       m_pend = 1'b0;
    bit       m_flag = 1'b0;
    bit       m_wave = 1'b0;

    task automatic check(string req, string what, bit act, bit expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, expv);
        end
    endtask

    // monitor: one expected item per driven cycle, compared after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, "cmp_flag", cmp_flag, e.flag);
                check(e.req, "irq", irq, e.irq);
                check(e.req, "wave_out", wave_out, e.wave);
            end
        end
    end

    task automatic step(string req, bit tk, bit [7:0] cnt, bit wr = 0, bit [7:0] wd = 0,
                        bit fc = 0, bit fw = 0, bit fd = 0, bit ack = 0);
        exp_t e;
        bit   hit;
        @(negedge clk);
        tick = tk; count = cnt; cmp_wr = wr; cmp_wdata = wd;
        force_cmp = fc; flag_wr = fw; flag_wdata = fd; vec_ack = ack;
        hit = tk && !m_blk && (cnt == m_cmp);
        if (tk && m_pend)           m_flag = 1'b1;   // set wins (R9)
        else if (ack || (fw && fd)) m_flag = 1'b0;
        if (hit || fc) begin
            case (wave_act)
                2'b01: m_wave = ~m_wave;
                2'b10: m_wave = 1'b0;
                2'b11: m_wave = 1'b1;
                default: ;
            endcase
        end
        if (tk) m_pend = hit;
        if (wr) begin m_cmp = wd; m_blk = 1'b1; end
        else if (tk) m_blk = 1'b0;
        e.req = req; e.flag = m_flag; e.irq = m_flag && irq_en && gie; e.wave = m_wave;
        exp_q.push_back(e);
        @(posedge clk);
        #3;
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R10", "cmp_flag", cmp_flag, 1'b0);
        check("R10", "irq", irq, 1'b0);
        check("R10", "wave_out", wave_out, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R1: match at count 10, flag one tick later; toggle action (R6)
        step("R1", 1, 8'd0, 1, 8'd10);
        for (int i = 1; i <= 12; i++) step("R1", 1, i[7:0]);
        // R4: zero write keeps, one write clears
        step("R4", 1, 8'd13, 0, 0, 0, 1, 0);
        step("R4", 1, 8'd14, 0, 0, 0, 1, 1);
        step("R4", 1, 8'd15);
        // R5: gating of the request
        gie = 1'b0;
        step("R5", 1, 8'd10);
        step("R5", 1, 8'd11);
        step("R5", 1, 8'd12);
        irq_en = 1'b0; gie = 1'b1;
        step("R5", 1, 8'd13);
        irq_en = 1'b1;
        step("R5", 1, 8'd14);
        // R3: acknowledge clears
        step("R3", 1, 8'd15, 0, 0, 0, 0, 0, 1);
        step("R3", 1, 8'd16);
        // R2 and R6: forced compare with set and clear actions
        wave_act = 2'b11;
        step("R2", 1, 8'd50, 0, 0, 1);
        step("R2", 1, 8'd51);
        step("R2", 1, 8'd52);
        wave_act = 2'b10;
        step("R6", 1, 8'd53, 0, 0, 1);
        wave_act = 2'b00;
        step("R6", 1, 8'd54, 0, 0, 1);
        // R6: match and force together apply once
        wave_act = 2'b01;
        step("R6", 1, 8'd10, 0, 0, 1);
        step("R6", 1, 8'd11);
        step("R6", 1, 8'd12, 0, 0, 0, 1, 1);
        // R7: write equal to the next count is blocked
        step("R7", 1, 8'd20, 1, 8'd21);
        step("R7", 1, 8'd21);
        step("R7", 1, 8'd22);
        step("R7", 1, 8'd23);
        step("R7", 1, 8'd21);
        step("R7", 1, 8'd22);
        step("R7", 1, 8'd23, 0, 0, 0, 0, 0, 1);
        // R8: tick-low cycles neither match nor advance the pending match
        step("R8", 0, 8'd21);
        step("R8", 0, 8'd21);
        step("R8", 1, 8'd21);
        step("R8", 0, 8'd22);
        step("R8", 0, 8'd22);
        step("R8", 0, 8'd22);
        step("R8", 1, 8'd22);
        step("R8", 1, 8'd23, 0, 0, 0, 1, 1);
        // R9: set coincides with ack, then with clear-by-one
        step("R9", 1, 8'd21);
        step("R9", 1, 8'd22, 0, 0, 0, 0, 0, 1);
        step("R9", 1, 8'd23, 0, 0, 0, 1, 1);
        step("R9", 1, 8'd21);
        step("R9", 1, 8'd22, 0, 0, 0, 1, 1);
        step("R9", 1, 8'd23);

        @(posedge clk);
        #5;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule